// File: doc/BRIEF.md
# Backplane Clock Master Handover Controller

This block decides whether a board drives the shared backplane clock and frame sync, and it hands that job between boards over a single wired-OR CLKFAIL line. The board that is master holds CLKFAIL low. When software clears the master bit, the board keeps driving until the next frame boundary. It then stops and drives CLKFAIL high for one clock before it releases the line. A standby board that is armed and is watching the line sees CLKFAIL high on two samples in a row. It then sets its own master bit and starts driving, so the frame timing carries on without a break.

Two status latches sit beside the handover logic. The first records the chosen level of CLKFAIL, with optional debounce. The second records a frame sync mismatch while the board is master. Both latches feed one interrupt request, which has a mask and a selectable output polarity.

Top module: `bus_clkmaster_ctl`

## Requirements
- R1: Reset clears these outputs: `master_en`, `drive_clk`, `clkfail_oe`, `clkfail_out`, `cf_latch` and `merr_latch`.
- R2: A write strobe `mst_wr` loads `mst_wdata` into `master_en` at the next edge. Once `master_en` is 1 and the line is idle, `drive_clk` and `clkfail_oe` rise one clock later, with `clkfail_out` at 0, which pulls CLKFAIL low.
- R3: After `master_en` clears, `drive_clk` stays 1 until an edge at which `frame_bnd` is 1. Setting `master_en` again before that edge keeps driving without a gap.
- R4: On the edge that ends driving, `drive_clk` falls. The block then holds `clkfail_oe`=1 with `clkfail_out`=1 for exactly one clock, after which `clkfail_oe` returns to 0.
- R5: An idle unit with `arm_en`=1, `mon_en`=1 and `master_en`=0 sets `master_en` once it samples `clkfail_in`=1 on two consecutive edges. It then raises `drive_clk` within 4 clocks of `clkfail_in` going high.
- R6: No takeover occurs in any of these cases: a single high sample, `arm_en`=0, `mon_en`=0, or a high sample taken while the unit drives the line itself.
- R7: `cf_latch` sets at an edge where `clkfail_in` equals `pol_sel`, so 0 selects the low level and 1 selects the high level.
- R8: When `dbnc_en`=1, `cf_latch` sets only if `clkfail_in` has the same value at two consecutive edges.
- R9: While `latch_clr_n`=0, `cf_latch` is held at 0.
- R10: `merr_latch` sets at an edge where `drive_clk`=1 and `fs_int`≠`fs_bus`. It holds its value until `merr_clr_n`=0.
- R11: `irq` is computed as active = `irq_mask_n` AND (`cf_latch` OR `merr_latch`). It equals active when `irq_pol_hi`=1 and the inverse of active when `irq_pol_hi`=0, so mask 0 with polarity 0 gives `irq`=1.
- R12: A software write takes priority over an automatic takeover in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_wr | input | 1 | Write strobe for the master bit |
| mst_wdata | input | 1 | Value written to the master bit |
| arm_en | input | 1 | Standby armed for takeover |
| mon_en | input | 1 | CLKFAIL monitoring enabled |
| clkfail_in | input | 1 | Sampled CLKFAIL line level |
| frame_bnd | input | 1 | Frame boundary strobe |
| fs_int | input | 1 | Internally generated frame sync |
| fs_bus | input | 1 | Frame sync seen on the bus |
| pol_sel | input | 1 | Level of CLKFAIL that sets the latch |
| dbnc_en | input | 1 | Two-sample debounce for the CLKFAIL latch |
| latch_clr_n | input | 1 | Active-low hold-clear of the CLKFAIL latch |
| merr_clr_n | input | 1 | Active-low hold-clear of the master error latch |
| irq_mask_n | input | 1 | 1 lets the interrupt through |
| irq_pol_hi | input | 1 | 1 makes the interrupt active high |
| master_en | output | 1 | Master enable bit |
| drive_clk | output | 1 | Drive enable for the clock and frame sync |
| clkfail_oe | output | 1 | Drive enable for CLKFAIL |
| clkfail_out | output | 1 | Level driven on CLKFAIL |
| cf_latch | output | 1 | CLKFAIL latch |
| merr_latch | output | 1 | Master error latch |
| irq | output | 1 | Interrupt request |

## Verification
The checks assume that `pol_sel` changes only while `latch_clr_n` is 0, and one check guards exactly that. The stimulus therefore changes polarity only inside a clear window. The checks also assume that all inputs are synchronous to `clk`. The bench changes its inputs just after a rising edge and never drives `clkfail_in` high while the unit is itself pulling the line low, which keeps the modelled wired-OR line consistent.

// File: rtl/bus_clkmaster_pkg.sv
package bus_clkmaster_pkg;
  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_DRIVE   = 2'd1,
    HS_WAIT_FB = 2'd2,
    HS_RELEASE = 2'd3
  } hs_state_t;

  // interrupt pin level from latches, mask and polarity
  function automatic logic irq_level(input logic cf, input logic merr,
                                     input logic mask_n, input logic pol_hi);
    logic act;
    act = mask_n & (cf | merr);
    return pol_hi ? act : ~act;
  endfunction

  // condition for a CLKFAIL latch set event
  function automatic logic cf_set_cond(input logic lvl, input logic prev,
                                       input logic pol, input logic dbnc);
    return (lvl == pol) && (!dbnc || (lvl == prev));
  endfunction
endpackage

// File: rtl/bcm_handover.sv
module bcm_handover
  import bus_clkmaster_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mst_wr,
  input  logic mst_wdata,
  input  logic arm_en,
  input  logic mon_en,
  input  logic clkfail_in,
  input  logic frame_bnd,
  output logic master_en,
  output logic drive_clk,
  output logic clkfail_oe,
  output logic clkfail_out,
  output logic take_ev
);
  hs_state_t st_q, st_d;
  logic      seen_hi_q;   // previous edge saw the line high while not driving it
  logic      line_own;

  assign line_own  = (st_q != HS_IDLE);
  assign take_ev   = (st_q == HS_IDLE) && arm_en && mon_en && !master_en &&
                     clkfail_in && seen_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      seen_hi_q <= 1'b0;
    end else begin
      seen_hi_q <= clkfail_in && !line_own;
      if (mst_wr)       master_en <= mst_wdata;
      else if (take_ev) master_en <= 1'b1;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_IDLE:    st_d = master_en ? HS_DRIVE : HS_IDLE;
      HS_DRIVE,
      HS_WAIT_FB: begin
        if (master_en)      st_d = HS_DRIVE;
        else if (frame_bnd) st_d = HS_RELEASE;
        else                st_d = HS_WAIT_FB;
      end
      HS_RELEASE: st_d = HS_IDLE;
      default:    st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_IDLE;
    else        st_q <= st_d;
  end

  assign drive_clk   = (st_q == HS_DRIVE) || (st_q == HS_WAIT_FB);
  assign clkfail_oe  = line_own;
  assign clkfail_out = (st_q == HS_RELEASE);

  // R3
  keep_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_clk && !frame_bnd |=> drive_clk);
  // R4
  release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkfail_out |=> !clkfail_oe && !drive_clk);
  // R4
  stop_then_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_clk && !master_en && frame_bnd |=> clkfail_out);
  // R5
  takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev && !mst_wr |=> master_en);
  // R2
  pull_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_clk |-> clkfail_oe && !clkfail_out);
endmodule

// File: rtl/bcm_cf_latch.sv
module bcm_cf_latch
  import bus_clkmaster_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clkfail_in,
  input  logic pol_sel,
  input  logic dbnc_en,
  input  logic latch_clr_n,
  output logic cf_latch,
  output logic cf_set_ev
);
  logic prev_q;

  assign cf_set_ev = cf_set_cond(clkfail_in, prev_q, pol_sel, dbnc_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      cf_latch <= 1'b0;
    end else begin
      prev_q <= clkfail_in;
      if (!latch_clr_n)   cf_latch <= 1'b0;
      else if (cf_set_ev) cf_latch <= 1'b1;
    end
  end

  // R9
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_clr_n |=> !cf_latch);
  // R7
  pol_only_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr_n |-> $stable(pol_sel));
  // R8
  dbnc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr_n && !$past(cf_latch) && cf_latch && $past(dbnc_en) |->
      $past(clkfail_in) == $past(prev_q));
endmodule

// File: rtl/bcm_merr_latch.sv
module bcm_merr_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_clk,
  input  logic fs_int,
  input  logic fs_bus,
  input  logic merr_clr_n,
  output logic merr_latch
);
  logic mismatch;
  assign mismatch = drive_clk && (fs_int != fs_bus);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          merr_latch <= 1'b0;
    else if (!merr_clr_n) merr_latch <= 1'b0;
    else if (mismatch)    merr_latch <= 1'b1;
  end

  // R10
  merr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merr_clr_n && drive_clk && (fs_int != fs_bus) |=> merr_latch);
  // R10
  merr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merr_clr_n && merr_latch |=> merr_latch);
endmodule

// File: rtl/bus_clkmaster_ctl.sv
module bus_clkmaster_ctl
  import bus_clkmaster_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mst_wr,
  input  logic mst_wdata,
  input  logic arm_en,
  input  logic mon_en,
  input  logic clkfail_in,
  input  logic frame_bnd,
  input  logic fs_int,
  input  logic fs_bus,
  input  logic pol_sel,
  input  logic dbnc_en,
  input  logic latch_clr_n,
  input  logic merr_clr_n,
  input  logic irq_mask_n,
  input  logic irq_pol_hi,
  output logic master_en,
  output logic drive_clk,
  output logic clkfail_oe,
  output logic clkfail_out,
  output logic cf_latch,
  output logic merr_latch,
  output logic irq
);
  logic take_ev;
  logic cf_set_ev;

  bcm_handover u_hand (
    .clk(clk), .rst_n(rst_n), .mst_wr(mst_wr), .mst_wdata(mst_wdata),
    .arm_en(arm_en), .mon_en(mon_en), .clkfail_in(clkfail_in),
    .frame_bnd(frame_bnd), .master_en(master_en), .drive_clk(drive_clk),
    .clkfail_oe(clkfail_oe), .clkfail_out(clkfail_out), .take_ev(take_ev)
  );

  bcm_cf_latch u_cfl (
    .clk(clk), .rst_n(rst_n), .clkfail_in(clkfail_in), .pol_sel(pol_sel),
    .dbnc_en(dbnc_en), .latch_clr_n(latch_clr_n), .cf_latch(cf_latch),
    .cf_set_ev(cf_set_ev)
  );

  bcm_merr_latch u_mel (
    .clk(clk), .rst_n(rst_n), .drive_clk(drive_clk), .fs_int(fs_int),
    .fs_bus(fs_bus), .merr_clr_n(merr_clr_n), .merr_latch(merr_latch)
  );

  assign irq = irq_level(cf_latch, merr_latch, irq_mask_n, irq_pol_hi);

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask_n |-> irq == !irq_pol_hi);
  // R7
  cf_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr_n && cf_set_ev |=> cf_latch);
  // R5
  take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |-> !drive_clk && !clkfail_oe);
endmodule

// File: tb/test_bus_clkmaster_ctl.sv
`timescale 1ns/1ps
module test_bus_clkmaster_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mst_wr = 0, mst_wdata = 0, arm_en = 0, mon_en = 0, clkfail_in = 1;
  logic frame_bnd = 0, fs_int = 0, fs_bus = 0, pol_sel = 0, dbnc_en = 0;
  logic latch_clr_n = 0, merr_clr_n = 0, irq_mask_n = 0, irq_pol_hi = 0;
  logic master_en, drive_clk, clkfail_oe, clkfail_out, cf_latch, merr_latch, irq;

  int n_vec = 0, n_bad = 0, wd = 0;

  always #4 clk = ~clk;

  bus_clkmaster_ctl i_bus_clkmaster_ctl (.*);

  // behavioural reference: integer state 0 idle, 1 drive, 2 wait, 3 release
  int  m_st = 0;
  bit  m_en = 0, m_hist = 0, m_prev = 1, m_cf = 0, m_merr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_hist = 0; m_prev = 1; m_cf = 0; m_merr = 0;
    end else begin
      bit own, take, nen, cfset, nhist, ncf, nmerr;
      int nst;
      own   = (m_st != 0);
      take  = (m_st == 0) && arm_en && mon_en && !m_en && clkfail_in && m_hist;
      nhist = clkfail_in && !own;
      nen   = mst_wr ? mst_wdata : (take ? 1'b1 : m_en);
      if (m_st == 0)      nst = m_en ? 1 : 0;
      else if (m_st == 3) nst = 0;
      else                nst = m_en ? 1 : (frame_bnd ? 3 : 2);
      cfset = (clkfail_in == pol_sel) && (!dbnc_en || clkfail_in == m_prev);
      ncf   = !latch_clr_n ? 1'b0 : (cfset ? 1'b1 : m_cf);
      nmerr = !merr_clr_n ? 1'b0 :
              (((m_st == 1 || m_st == 2) && fs_int != fs_bus) ? 1'b1 : m_merr);
      m_prev = clkfail_in; m_hist = nhist; m_en = nen; m_st = nst;
      m_cf = ncf; m_merr = nmerr;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the rising edge
  always @(negedge clk) if (rst_n) begin
    bit e_irq;
    e_irq = irq_pol_hi ? (irq_mask_n & (m_cf | m_merr)) : !(irq_mask_n & (m_cf | m_merr));
    chk(master_en == m_en, "R5/R12 master_en", master_en, m_en);
    chk(drive_clk == (m_st == 1 || m_st == 2), "R2/R3 drive_clk", drive_clk, (m_st == 1 || m_st == 2));
    chk(clkfail_oe == (m_st != 0), "R4 clkfail_oe", clkfail_oe, (m_st != 0));
    chk(clkfail_out == (m_st == 3), "R4 clkfail_out", clkfail_out, (m_st == 3));
    chk(cf_latch == m_cf, "R7/R8/R9 cf_latch", cf_latch, m_cf);
    chk(merr_latch == m_merr, "R10 merr_latch", merr_latch, m_merr);
    chk(irq == e_irq, "R11 irq", irq, e_irq);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int cnt;
    step(2);
    // R1: reset state
    chk(!master_en && !drive_clk && !clkfail_oe && !clkfail_out && !cf_latch && !merr_latch,
        "R1 reset", drive_clk, 0);
    rst_n = 1;
    step(2);
    // R2: become master by write
    mst_wr = 1; mst_wdata = 1; step(1); mst_wr = 0;
    step(3);
    chk(drive_clk && clkfail_oe && !clkfail_out, "R2 driving low", drive_clk, 1);
    // R10: frame sync mismatch while master
    merr_clr_n = 1; fs_int = 1; step(1); fs_int = 0; step(2);
    chk(merr_latch, "R10 merr set", merr_latch, 1);
    merr_clr_n = 0; step(1); merr_clr_n = 1;
    // R3: disable, keep driving until boundary; re-enable before boundary
    mst_wr = 1; mst_wdata = 0; step(1); mst_wr = 0; step(4);
    chk(drive_clk, "R3 still driving", drive_clk, 1);
    mst_wr = 1; mst_wdata = 1; step(1); mst_wr = 0; step(2);
    chk(drive_clk, "R3 resumed", drive_clk, 1);
    mst_wr = 1; mst_wdata = 0; step(1); mst_wr = 0; step(3);
    frame_bnd = 1; step(1); frame_bnd = 0;
    // R4: one-clock high pulse
    chk(clkfail_oe && clkfail_out && !drive_clk, "R4 pulse", clkfail_out, 1);
    step(1);
    chk(!clkfail_oe, "R4 released", clkfail_oe, 0);
    // R6: no takeover without arm / monitor / on single sample
    clkfail_in = 1; step(4);
    chk(!master_en, "R6 unarmed", master_en, 0);
    arm_en = 1; step(3);
    chk(!master_en, "R6 unmonitored", master_en, 0);
    clkfail_in = 0; mon_en = 1; step(2);
    clkfail_in = 1; step(1); clkfail_in = 0; step(3);
    chk(!master_en, "R6 single sample", master_en, 0);
    // R5: takeover within 4 clocks
    clkfail_in = 1; cnt = 0;
    while (!drive_clk && cnt < 8) begin step(1); cnt++; end
    clkfail_in = 0;
    chk(cnt <= 4 && drive_clk, "R5 takeover latency", cnt, 4);
    step(2);
    // R12: write wins over takeover in same cycle
    mst_wr = 1; mst_wdata = 0; step(1); mst_wr = 0;
    frame_bnd = 1; step(1); frame_bnd = 0; step(3);
    clkfail_in = 1; step(1);
    mst_wr = 1; mst_wdata = 0; step(1); mst_wr = 0;
    chk(!master_en, "R12 write priority", master_en, 0);
    arm_en = 0; step(2);
    // R7 / R9: polarity changed only inside clear window
    latch_clr_n = 0; pol_sel = 1; step(2);
    chk(!cf_latch, "R9 held clear", cf_latch, 0);
    latch_clr_n = 1; step(2);
    chk(cf_latch, "R7 high polarity", cf_latch, 1);
    irq_mask_n = 1; irq_pol_hi = 1; step(1);
    chk(irq, "R11 active high", irq, 1);
    irq_pol_hi = 0; step(1);
    chk(!irq, "R11 active low", irq, 0);
    latch_clr_n = 0; pol_sel = 0; clkfail_in = 1; step(2);
    latch_clr_n = 1; step(2);
    chk(!cf_latch, "R7 low polarity ignores high", cf_latch, 0);
    // R8: debounce needs two equal samples
    dbnc_en = 1; clkfail_in = 0; step(1); clkfail_in = 1; step(1);
    chk(!cf_latch, "R8 single low rejected", cf_latch, 0);
    clkfail_in = 0; step(3);
    chk(cf_latch, "R8 stable low accepted", cf_latch, 1);
    irq_mask_n = 0; step(2);
    chk(irq, "R11 masked idle level", irq, 1);
    step(4);
    summary();
  end
endmodule